// File: doc/BRIEF.md
# I2C Master Interrupt Status Unit

This block gathers every interrupt condition of an I2C master controller into one place for a host. The bus engine reports one-cycle event pulses, such as a detected stop or a transfer abort. The FIFOs report their fill levels together with programmed thresholds. Each event sets a sticky raw bit. The two FIFO conditions are level sources that track their comparisons directly.

A mask register selects which raw bits reach the masked view. The single interrupt line is the OR of that view, gated by the controller enable. The host bus logic turns register reads into clear strobes: one strobe per event source, plus a strobe that clears every event at once. Because each source is cleared individually, an event that arrives after the status was read and before it is acknowledged is not lost. The reason for an abort is latched beside the abort bit and stays readable until that bit is acknowledged.

Top module: `i2cm_irq_ctrl`

## Requirements
- R1: `masked_stat` always equals `raw_stat & mask_q`. A write with `mask_we` loads `mask_wdata` into `mask_q` at the next clock edge.
- R2: An event bit in `raw_stat[9:0]` is set one edge after its `evt_pulse` bit is high. It then stays set until a clear strobe reaches it. The bit layout is 0 abort, 1 stop seen, 2 start seen, 3 bus activity, 4 receive done, 5 read request, 6 general call, 7 receive underflow, 8 receive overflow, 9 transmit overflow.
- R3: A high `rd_clr[i]` clears only event bit i at the next edge. All other bits are left unchanged.
- R4: `rd_clr_all` clears all ten event bits at the next edge. It has no effect on the two level bits.
- R5: When an event pulse and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R6: `raw_stat[10]` (transmit empty) is high exactly while `txf_level <= txf_thresh`. It has no clear strobe.
- R7: `raw_stat[11]` (receive full) is high exactly while `rxf_level > rxf_thresh`. With a threshold of 0, a single stored byte raises it.
- R8: On an abort pulse, `abort_cause` loads `abort_why`. Further aborts while the bit is pending OR their reasons into it. It returns to zero when the abort bit is cleared without a new abort in that cycle; a clear together with a new abort leaves only the new reason. Outside an abort pulse, `abort_why` is ignored.
- R9: `irq` is high exactly when `ctrl_en` is high and some bit of `masked_stat` is set. It is low whenever `ctrl_en` is low.
- R10: After reset, all event bits and `abort_cause` are zero and `mask_q` holds the reset mask (all zeros by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enabled; gates `irq` |
| evt_pulse | input | 10 | One-cycle event pulses from the bus engine |
| abort_why | input | CAUSE_W | Abort reason, valid with `evt_pulse[0]` |
| txf_level | input | LVL_W | Transmit FIFO fill level |
| txf_thresh | input | LVL_W | Transmit empty threshold |
| rxf_level | input | LVL_W | Receive FIFO fill level |
| rxf_thresh | input | LVL_W | Receive full threshold |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | Mask register write data |
| rd_clr | input | 10 | Per-event clear-on-read strobes |
| rd_clr_all | input | 1 | Combined clear strobe |
| raw_stat | output | 12 | Unmasked status vector |
| mask_q | output | 12 | Current mask register |
| masked_stat | output | 12 | Masked status vector |
| abort_cause | output | CAUSE_W | Latched abort reason |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is stable around the rising clock edge. They also assume that `rd_clr` and `evt_pulse` are asserted as plain one-cycle strobes, with the level and threshold inputs held between edges. The bench changes every input two nanoseconds after a rising edge and holds it for the full cycle. Its random phase draws levels only inside the FIFO span. Events and clears are drawn at moderate density, so sets, clears and their collisions all occur.

// File: rtl/i2cm_irq_pkg.sv
`timescale 1ns/1ps
package i2cm_irq_pkg;
   // Event sources (sticky), positions are visible to software
   localparam int unsigned EV_ABORT    = 0;
   localparam int unsigned EV_STOP     = 1;
   localparam int unsigned EV_START    = 2;
   localparam int unsigned EV_ACTIVITY = 3;
   localparam int unsigned EV_RX_DONE  = 4;
   localparam int unsigned EV_RD_REQ   = 5;
   localparam int unsigned EV_GEN_CALL = 6;
   localparam int unsigned EV_RX_UNDER = 7;
   localparam int unsigned EV_RX_OVER  = 8;
   localparam int unsigned EV_TX_OVER  = 9;
   localparam int unsigned NUM_EVT     = 10;
   // Level sources follow FIFO comparisons
   localparam int unsigned LV_TX_EMPTY = NUM_EVT;
   localparam int unsigned LV_RX_FULL  = NUM_EVT + 1;
   localparam int unsigned NUM_SRC     = NUM_EVT + 2;

   typedef logic [NUM_EVT-1:0] evt_vec_t;
   typedef logic [NUM_SRC-1:0] src_vec_t;

   typedef enum logic {
      CMP_AT_OR_BELOW = 1'b0,
      CMP_ABOVE       = 1'b1
   } lvl_cmp_e;
endpackage

// File: rtl/i2cm_irq_sticky.sv
`timescale 1ns/1ps
module i2cm_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // A set in the same cycle as a clear keeps the bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/i2cm_irq_level.sv
`timescale 1ns/1ps
module i2cm_irq_level
   import i2cm_irq_pkg::*;
#(
   parameter int unsigned LVL_W = 5,
   parameter lvl_cmp_e    MODE  = CMP_AT_OR_BELOW
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] thresh_i,
   output logic             hit_o
);
   generate
      if (MODE == CMP_ABOVE) begin : g_above
         assign hit_o = (level_i > thresh_i);
      end else begin : g_below
         assign hit_o = (level_i <= thresh_i);
      end
   endgenerate
endmodule

// File: rtl/i2cm_irq_cause.sv
`timescale 1ns/1ps
module i2cm_irq_cause #(
   parameter int unsigned CAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture_i,
   input  logic               release_i,
   input  logic [CAUSE_W-1:0] why_i,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [CAUSE_W-1:0] base;

   // A release in the capture cycle drops old reasons, keeps the new one
   assign base = release_i ? '0 : cause_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cause_o <= '0;
      else if (capture_i) cause_o <= base | why_i;
      else if (release_i) cause_o <= '0;
   end
endmodule

// File: rtl/i2cm_irq_ctrl.sv
`timescale 1ns/1ps
module i2cm_irq_ctrl
   import i2cm_irq_pkg::*;
#(
   parameter int unsigned        LVL_W      = 5,
   parameter int unsigned        CAUSE_W    = 8,
   parameter logic [NUM_SRC-1:0] MASK_RESET = '0,
   parameter bit                 IRQ_REG    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_en,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic [CAUSE_W-1:0] abort_why,
   input  logic [LVL_W-1:0]   txf_level,
   input  logic [LVL_W-1:0]   txf_thresh,
   input  logic [LVL_W-1:0]   rxf_level,
   input  logic [LVL_W-1:0]   rxf_thresh,
   input  logic               mask_we,
   input  logic [NUM_SRC-1:0] mask_wdata,
   input  logic [NUM_EVT-1:0] rd_clr,
   input  logic               rd_clr_all,
   output logic [NUM_SRC-1:0] raw_stat,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] masked_stat,
   output logic [CAUSE_W-1:0] abort_cause,
   output logic               irq
);
   // Elaboration-time parameter checks
   generate
      if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
         $error("i2cm_irq_ctrl: LVL_W must be within 1..16");
      end
      if (CAUSE_W < 1 || CAUSE_W > 32) begin : g_bad_cause
         $error("i2cm_irq_ctrl: CAUSE_W must be within 1..32");
      end
   endgenerate

   evt_vec_t clr_eff;
   evt_vec_t evt_q;
   logic     tx_hit;
   logic     rx_hit;
   logic     any_pending;

   assign clr_eff = rd_clr | {NUM_EVT{rd_clr_all}};

   // Sticky event bits
   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
         i2cm_irq_sticky u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_pulse[i]),
            .clr_i (clr_eff[i]),
            .q_o   (evt_q[i])
         );
      end
   endgenerate

   // Level sources
   i2cm_irq_level #(.LVL_W(LVL_W), .MODE(CMP_AT_OR_BELOW)) u_tx_lvl (
      .level_i  (txf_level),
      .thresh_i (txf_thresh),
      .hit_o    (tx_hit)
   );

   i2cm_irq_level #(.LVL_W(LVL_W), .MODE(CMP_ABOVE)) u_rx_lvl (
      .level_i  (rxf_level),
      .thresh_i (rxf_thresh),
      .hit_o    (rx_hit)
   );

   // Abort reason held alongside the abort bit
   i2cm_irq_cause #(.CAUSE_W(CAUSE_W)) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (evt_pulse[EV_ABORT]),
      .release_i (clr_eff[EV_ABORT]),
      .why_i     (abort_why),
      .cause_o   (abort_cause)
   );

   // Mask register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= MASK_RESET;
      else if (mask_we) mask_q <= mask_wdata;
   end

   always_comb begin
      raw_stat               = '0;
      raw_stat[NUM_EVT-1:0]  = evt_q;
      raw_stat[LV_TX_EMPTY]  = tx_hit;
      raw_stat[LV_RX_FULL]   = rx_hit;
   end

   assign masked_stat = raw_stat & mask_q;
   assign any_pending = |masked_stat;

   // Output variant
   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= ctrl_en & any_pending;
         end
      end else begin : g_irq_comb
         assign irq = ctrl_en & any_pending;
      end
   endgenerate
endmodule

// File: rtl/i2cm_irq_ctrl_chk.sv
`timescale 1ns/1ps
module i2cm_irq_ctrl_chk
   import i2cm_irq_pkg::*;
#(
   parameter int unsigned LVL_W   = 5,
   parameter int unsigned CAUSE_W = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctrl_en,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic [NUM_EVT-1:0] rd_clr,
   input logic               rd_clr_all,
   input logic [LVL_W-1:0]   txf_level,
   input logic [LVL_W-1:0]   txf_thresh,
   input logic [LVL_W-1:0]   rxf_level,
   input logic [LVL_W-1:0]   rxf_thresh,
   input logic [NUM_SRC-1:0] raw_stat,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] masked_stat,
   input logic [CAUSE_W-1:0] abort_cause,
   input logic               irq
);
   logic [NUM_EVT-1:0] clr_seen;
   logic [NUM_EVT-1:0] keep;
   logic [NUM_EVT-1:0] drop;

   assign clr_seen = rd_clr | {NUM_EVT{rd_clr_all}};
   assign keep     = raw_stat[NUM_EVT-1:0] & ~clr_seen;
   assign drop     = clr_seen & ~evt_pulse;

   a_r1_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
      masked_stat == (raw_stat & mask_q));

   a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_stat[NUM_EVT-1:0] & $past(keep)) == $past(keep)));

   a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_stat[NUM_EVT-1:0] & $past(drop)) == '0));

   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_stat[NUM_EVT-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

   a_r6_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
      raw_stat[LV_TX_EMPTY] == (txf_level <= txf_thresh));

   a_r7_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
      raw_stat[LV_RX_FULL] == (rxf_level > rxf_thresh));

   a_r8_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_stat[EV_ABORT] |-> (abort_cause == '0));

   generate
      if (IRQ_REG) begin : g_chk_ff
         a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == $past(ctrl_en && (masked_stat != '0))));
      end else begin : g_chk_comb
         a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (ctrl_en && (masked_stat != '0)));
         a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_en |-> !irq);
      end
   endgenerate
endmodule

bind i2cm_irq_ctrl i2cm_irq_ctrl_chk #(
   .LVL_W   (LVL_W),
   .CAUSE_W (CAUSE_W),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_en     (ctrl_en),
   .evt_pulse   (evt_pulse),
   .rd_clr      (rd_clr),
   .rd_clr_all  (rd_clr_all),
   .txf_level   (txf_level),
   .txf_thresh  (txf_thresh),
   .rxf_level   (rxf_level),
   .rxf_thresh  (rxf_thresh),
   .raw_stat    (raw_stat),
   .mask_q      (mask_q),
   .masked_stat (masked_stat),
   .abort_cause (abort_cause),
   .irq         (irq)
);

// File: tb/i2cm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module i2cm_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b0;
   logic [9:0]  evt_pulse = '0;
   logic [7:0]  abort_why = '0;
   logic [4:0]  txf_level = '0;
   logic [4:0]  txf_thresh = '0;
   logic [4:0]  rxf_level = '0;
   logic [4:0]  rxf_thresh = '0;
   logic        mask_we = 1'b0;
   logic [11:0] mask_wdata = '0;
   logic [9:0]  rd_clr = '0;
   logic        rd_clr_all = 1'b0;
   logic [11:0] raw_stat;
   logic [11:0] mask_q;
   logic [11:0] masked_stat;
   logic [7:0]  abort_cause;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [9:0]  m_evt;
   logic [11:0] m_mask;
   logic [7:0]  m_cause;

   always #10 clk = ~clk;

   i2cm_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .evt_pulse(evt_pulse),
      .abort_why(abort_why), .txf_level(txf_level), .txf_thresh(txf_thresh),
      .rxf_level(rxf_level), .rxf_thresh(rxf_thresh), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .rd_clr(rd_clr), .rd_clr_all(rd_clr_all),
      .raw_stat(raw_stat), .mask_q(mask_q), .masked_stat(masked_stat),
      .abort_cause(abort_cause), .irq(irq)
   );

   function automatic logic [9:0] f_evt(input logic [9:0] cur, input logic [9:0] ev,
                                        input logic [9:0] cl, input logic all);
      logic [9:0] c;
      c = cl | {10{all}};
      return (cur & ~c) | ev;
   endfunction

   function automatic logic [7:0] f_cause(input logic [7:0] cur, input logic ab,
                                          input logic rel, input logic [7:0] why);
      if (ab)       return (rel ? 8'h00 : cur) | why;
      else if (rel) return 8'h00;
      return cur;
   endfunction

   function automatic logic [11:0] f_raw();
      return {rxf_level > rxf_thresh, txf_level <= txf_thresh, m_evt};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      logic [11:0] er;
      er = f_raw();
      chk("R2 event bits", 32'(raw_stat[9:0]), 32'(er[9:0]));
      chk("R6 transmit empty", 32'(raw_stat[10]), 32'(er[10]));
      chk("R7 receive full", 32'(raw_stat[11]), 32'(er[11]));
      chk("R1 mask register", 32'(mask_q), 32'(m_mask));
      chk("R1 masked view", 32'(masked_stat), 32'(er & m_mask));
      chk("R8 abort cause", 32'(abort_cause), 32'(m_cause));
      chk("R9 irq", 32'(irq), 32'(ctrl_en & (|(er & m_mask))));
   endtask

   task automatic step(input logic [9:0] ev, input logic [9:0] cl, input logic ca,
                       input logic [7:0] why, input logic mwe, input logic [11:0] md);
      evt_pulse = ev; rd_clr = cl; rd_clr_all = ca; abort_why = why;
      mask_we = mwe; mask_wdata = md;
      m_cause = f_cause(m_cause, ev[0], cl[0] | ca, why);
      m_evt   = f_evt(m_evt, ev, cl, ca);
      if (mwe) m_mask = md;
      @(posedge clk);
      #2;
      evt_pulse = '0; rd_clr = '0; rd_clr_all = 1'b0; mask_we = 1'b0; abort_why = '0;
      check_all();
   endtask

   task automatic idle();
      step('0, '0, 1'b0, 8'h00, 1'b0, 12'h000);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_evt = '0; m_mask = '0; m_cause = '0;
      repeat (3) @(posedge clk);
      #2;
      // R10: reset state
      chk("R10 reset raw", 32'(raw_stat), 32'h400);
      chk("R10 reset mask", 32'(mask_q), 32'h000);
      chk("R10 reset cause", 32'(abort_cause), 32'h00);
      chk("R10 reset irq", 32'(irq), 32'h0);
      rst_n = 1'b1;
      ctrl_en = 1'b1;
      idle();

      // R1: open all mask bits
      step('0, '0, 1'b0, 8'h00, 1'b1, 12'hFFF);
      // R2: stop event stays set
      step(10'h002, '0, 1'b0, 8'h00, 1'b0, 12'h000);
      idle(); idle(); idle();
      chk("R2 stop sticky", 32'(raw_stat[1]), 32'h1);
      // R3: clear of one bit leaves the neighbour
      step(10'h004, '0, 1'b0, 8'h00, 1'b0, 12'h000);
      step('0, 10'h002, 1'b0, 8'h00, 1'b0, 12'h000);
      chk("R3 single clear", 32'(raw_stat[2:1]), 32'h2);
      // R5: event and clear together
      step(10'h008, 10'h008, 1'b0, 8'h00, 1'b0, 12'h000);
      chk("R5 event wins", 32'(raw_stat[3]), 32'h1);
      // R4: combined clear, level bit untouched
      step('0, '0, 1'b1, 8'h00, 1'b0, 12'h000);
      chk("R4 clear all events", 32'(raw_stat[9:0]), 32'h000);
      chk("R4 level kept", 32'(raw_stat[10]), 32'h1);
      // R7: threshold zero, then three
      rxf_thresh = 5'd0; rxf_level = 5'd0; idle();
      chk("R7 empty rx", 32'(raw_stat[11]), 32'h0);
      rxf_level = 5'd1; idle();
      chk("R7 first byte", 32'(raw_stat[11]), 32'h1);
      rxf_thresh = 5'd3; rxf_level = 5'd3; idle();
      chk("R7 at threshold", 32'(raw_stat[11]), 32'h0);
      rxf_level = 5'd4; idle();
      chk("R7 above threshold", 32'(raw_stat[11]), 32'h1);
      // R6: transmit threshold boundary
      txf_thresh = 5'd4; txf_level = 5'd4; idle();
      chk("R6 at threshold", 32'(raw_stat[10]), 32'h1);
      txf_level = 5'd5; idle();
      chk("R6 above threshold", 32'(raw_stat[10]), 32'h0);
      // R8: abort reason latch
      step(10'h001, '0, 1'b0, 8'h05, 1'b0, 12'h000);
      chk("R8 first reason", 32'(abort_cause), 32'h05);
      step(10'h001, '0, 1'b0, 8'h30, 1'b0, 12'h000);
      chk("R8 accumulate", 32'(abort_cause), 32'h35);
      step('0, '0, 1'b0, 8'hFF, 1'b0, 12'h000);
      chk("R8 ignored reason", 32'(abort_cause), 32'h35);
      step(10'h001, 10'h001, 1'b0, 8'h40, 1'b0, 12'h000);
      chk("R8 clear with new abort", 32'(abort_cause), 32'h40);
      step('0, 10'h001, 1'b0, 8'h00, 1'b0, 12'h000);
      chk("R8 released", 32'(abort_cause), 32'h00);
      // R9: controller disabled
      ctrl_en = 1'b0;
      step(10'h002, '0, 1'b0, 8'h00, 1'b0, 12'h000);
      chk("R9 disabled low", 32'(irq), 32'h0);
      ctrl_en = 1'b1; idle();
      chk("R9 enabled high", 32'(irq), 32'h1);
      // R1: all masked off
      step('0, '0, 1'b0, 8'h00, 1'b1, 12'h000);
      chk("R1 masked zero", 32'(masked_stat), 32'h000);
      chk("R9 masked irq", 32'(irq), 32'h0);

      // Random phase
      for (int n = 0; n < 3000; n++) begin
         logic [9:0] ev;
         logic [9:0] cl;
         for (int b = 0; b < 10; b++) begin
            ev[b] = ($urandom % 8) == 0;
            cl[b] = ($urandom % 6) == 0;
         end
         if (($urandom % 64) == 0) ctrl_en = ~ctrl_en;
         txf_level  = 5'($urandom % 17);
         txf_thresh = 5'($urandom % 16);
         rxf_level  = 5'($urandom % 17);
         rxf_thresh = 5'($urandom % 16);
         step(ev, cl, ($urandom % 32) == 0, 8'($urandom),
              ($urandom % 16) == 0, 12'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule